// File: doc/BRIEF.md
# Clear-on-Read Network Statistics Counter Bank

This block keeps a set of network traffic and error counters for a MAC. Each counter has a width chosen for how often its event occurs. Frame counters are wide, collision and deferral counters are medium, and rare error counters are narrow. Single-cycle event pulses from the MAC advance the counters. The counters are packed into five 32-bit words that the host reads through a small byte-addressed window.

A host read returns one word and clears every counter packed into it in the same clock edge, so no count is lost or counted twice. An event that arrives in the same cycle as the clearing read restarts its counter at one. Counters saturate at all-ones instead of wrapping. Once any counter's most significant bit becomes set, a shared overflow request goes to the interrupt logic, and it stays up until the host has read every counter that caused it.

Top module: `stats_bank`

## Requirements
- R1: After a synchronous active-low reset, every counter is zero, `rd_data_o` is zero and `ovf_req_o` is low.
- R2: A one-cycle pulse on `evt_i[k]` adds exactly one to counter k.
- R3: A counter that holds all-ones stays at all-ones on further events until it is cleared.
- R4: A read with `rd_en_i` high at a valid word address puts that word on `rd_data_o` one clock later. `rd_data_o` is zero in every cycle that does not follow a valid read.
- R5: A valid read clears every counter in the addressed word at the same edge that captures the word. Counters in other words are untouched.
- R6: If an event hits a counter in the same cycle as the read that clears it, the returned value does not include that event and the counter then holds one.
- R7: `ovf_req_o` is high exactly while at least one counter has its most significant bit set. It therefore stays high until the read that clears the last such counter.
- R8: A read at an address outside 0x30..0x40, or one not aligned to four bytes, returns zero and clears nothing.
- R9: Word layout, with bit positions given from bit 0 upward:
  - 0x30: received good frames [23:0], receive overruns [31:24].
  - 0x34: transmitted good frames [23:0], transmit underruns [31:24].
  - 0x38: CRC errors [7:0], code errors [15:8], deferred transmits [31:16].
  - 0x3C: single collisions [15:0], multiple collisions [31:16].
  - 0x40: excessive collisions [7:0], late collisions [15:8], carrier losses [23:16].
  - Bits above a counter's configured width read as zero.
- R10: Events on any number of counters in the same cycle are all counted. Counter k is driven by `evt_i[k]`, with k following the order of the R9 list (0 = received good frames … 11 = carrier losses).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 12 | One-cycle event pulses, one bit per counter |
| rd_en_i | input | 1 | Host read strobe |
| rd_addr_i | input | 8 | Host byte address of the word to read |
| rd_data_o | output | 32 | Read word, valid one cycle after a read |
| ovf_req_o | output | 1 | Statistics overflow request to the interrupt logic |

## Verification
The bench builds the bank with 5-bit frame counters, 4-bit medium counters and 3-bit error counters. With these widths, the most significant bit and saturation are reached after a few dozen events rather than millions. That puts the overflow request, its release by reads, and saturation followed by a clearing read within a short run. Concurrent events, reads that coincide with events, and misaligned or out-of-window reads are mixed in by a pseudo-random phase. A behavioural model checks that phase on every clock.

// File: rtl/stats_pkg.sv
// Package: layout of the statistics counter bank.
// Gives each counter its word, bit offset, slot size and size class.
// Assumes 12 counters packed into 5 words of 32 bits.
package stats_pkg;

    localparam int NUM_CTR   = 12;
    localparam int NUM_WORDS = 5;
    localparam int WORD_W    = 32;
    localparam int MAX_SLOT  = 24;

    // Size classes: 0 = frame counter, 1 = medium, 2 = rare error.
    function automatic int ctr_class(input int id);
        case (id)
            0, 2:    return 0;
            6, 7, 8: return 1;
            default: return 2;
        endcase
    endfunction

    // Word index that holds a counter.
    function automatic int ctr_word(input int id);
        case (id)
            0, 1:     return 0;
            2, 3:     return 1;
            4, 5, 6:  return 2;
            7, 8:     return 3;
            default:  return 4;
        endcase
    endfunction

    // Lowest bit of a counter inside its word.
    function automatic int ctr_lsb(input int id);
        case (id)
            1, 3:     return 24;
            5, 10:    return 8;
            6, 8, 11: return 16;
            default:  return 0;
        endcase
    endfunction

    // Width of the slot reserved for a counter.
    function automatic int ctr_slot(input int id);
        case (ctr_class(id))
            0:       return 24;
            1:       return 16;
            default: return 8;
        endcase
    endfunction

    // Configured width of a counter, limited to its slot.
    function automatic int ctr_width(input int id, input int wf, input int wm, input int we);
        int w;
        case (ctr_class(id))
            0:       w = wf;
            1:       w = wm;
            default: w = we;
        endcase
        if (w > ctr_slot(id)) w = ctr_slot(id);
        if (w < 1) w = 1;
        return w;
    endfunction

endpackage

// File: rtl/stat_ctr.sv
// Module: one saturating statistics counter with synchronous clear.
// A clear that coincides with an event restarts the count at one.
// Assumes inc_i and clr_i are single-cycle, synchronous to clk.
module stat_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    localparam logic [W-1:0] MAXV = '1;
    localparam logic [W-1:0] ONE  = W'(1);

    // Count, saturate, or restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= inc_i ? ONE : '0;
        else if (inc_i && cnt_o != MAXV)
            cnt_o <= cnt_o + ONE;
    end

    // R2: an uncleared event below the ceiling adds one
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && inc_i && cnt_o != MAXV) |=> (cnt_o == $past(cnt_o) + ONE));

    // R3: a full counter stays full until cleared
    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && cnt_o == MAXV) |=> (cnt_o == MAXV));

    // R5: a clear with no event leaves zero
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !inc_i) |=> (cnt_o == '0));

    // R6: a clear with an event leaves one
    p_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && inc_i) |=> (cnt_o == ONE));

    // R2: with neither clear nor event, the value holds
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !inc_i) |=> $stable(cnt_o));

endmodule

// File: rtl/stat_decode.sv
// Module: address decode for the statistics window.
// Maps an aligned byte address inside the window to a one-hot word select.
// Assumes the window starts at BASE and spans NUM_WORDS consecutive words.
module stat_decode #(
    parameter int          ADDR_W    = 8,
    parameter int          NUM_WORDS = 5,
    parameter logic [7:0]  BASE      = 8'h30,
    localparam int         IDX_W     = $clog2(NUM_WORDS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_i,
    input  logic [ADDR_W-1:0]    addr_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     idx_o,
    output logic [NUM_WORDS-1:0] sel_o
);

    logic [ADDR_W-1:0] offset;
    logic              in_range;

    // Offset from the window base and range test.
    always_comb begin
        offset   = addr_i - ADDR_W'(BASE);
        in_range = (addr_i >= ADDR_W'(BASE)) &&
                   ({2'b00, offset[ADDR_W-1:2]} < ADDR_W'(NUM_WORDS)) &&
                   (addr_i[1:0] == 2'b00);
        hit_o    = en_i && in_range;
        idx_o    = offset[IDX_W+1:2];
    end

    // One select line per word.
    generate
        for (genvar w = 0; w < NUM_WORDS; w++) begin : g_sel
            assign sel_o[w] = hit_o && (idx_o == IDX_W'(w));
        end
    endgenerate

    // R8: at most one word is selected
    p_onehot_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel_o));

    // R8: no read strobe, no selection
    p_no_sel_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> (sel_o == '0));

endmodule

// File: rtl/stats_bank.sv
// Module: clear-on-read statistics counter bank (top).
// Holds 12 saturating counters packed into 5 words at 0x30..0x40.
// A read captures a word and clears its counters at the same edge.
// Raises an overflow request while any counter has its MSB set.
// Assumes event pulses and reads are synchronous to clk.
module stats_bank
    import stats_pkg::*;
#(
    parameter int         W_FRAME = 24,
    parameter int         W_MID   = 16,
    parameter int         W_ERR   = 8,
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] BASE    = 8'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [11:0]        evt_i,
    input  logic               rd_en_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [31:0]        rd_data_o,
    output logic               ovf_req_o
);

    localparam int IDX_W = $clog2(NUM_WORDS);

    logic                 hit;
    logic [IDX_W-1:0]     idx;
    logic [NUM_WORDS-1:0] sel;
    logic [MAX_SLOT-1:0]  cnt_ext [NUM_CTR];
    logic [NUM_CTR-1:0]   msb;
    logic [WORD_W-1:0]    word_val [NUM_WORDS];

    stat_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_WORDS(NUM_WORDS),
        .BASE     (BASE)
    ) u_dec (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (rd_en_i),
        .addr_i(rd_addr_i),
        .hit_o (hit),
        .idx_o (idx),
        .sel_o (sel)
    );

    // One counter per event line, sized by its class.
    generate
        for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
            localparam int CW = ctr_width(i, W_FRAME, W_MID, W_ERR);
            logic [CW-1:0] cnt;

            stat_ctr #(.W(CW)) u_ctr (
                .clk  (clk),
                .rst_n(rst_n),
                .inc_i(evt_i[i]),
                .clr_i(sel[ctr_word(i)]),
                .cnt_o(cnt)
            );

            assign cnt_ext[i] = MAX_SLOT'(cnt);
            assign msb[i]     = cnt[CW-1];
        end
    endgenerate

    // Pack counters into their words.
    always_comb begin
        for (int w = 0; w < NUM_WORDS; w++) word_val[w] = '0;
        for (int i = 0; i < NUM_CTR; i++)
            word_val[ctr_word(i)] = word_val[ctr_word(i)] |
                                    (WORD_W'(cnt_ext[i]) << ctr_lsb(i));
    end

    // Capture the addressed word; zero when no valid read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_data_o <= '0;
        else if (hit)
            rd_data_o <= word_val[idx];
        else
            rd_data_o <= '0;
    end

    // Overflow request from counter MSBs.
    assign ovf_req_o = |msb;

    // R8: an invalid read returns zero
    p_bad_addr_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !hit) |=> (rd_data_o == '0));

    // R4: no read, no data
    p_idle_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en_i |=> (rd_data_o == '0));

    // R7: without a read, the overflow request cannot drop
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_req_o && !rd_en_i) |=> ovf_req_o);

    // R7: without events, the overflow request cannot rise
    p_ovf_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_req_o && evt_i == '0) |=> !ovf_req_o);

endmodule

// File: tb/sim_stats_bank.sv
// Bench: behavioural model of the counter bank, compared every clock.
module sim_stats_bank;

    localparam int WF = 5;
    localparam int WM = 4;
    localparam int WE = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] evt = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ovf_req;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ref_cnt [12];
    logic [31:0] exp_data = '0;
    logic        exp_ovf = 1'b0;

    always #2 clk = ~clk;

    stats_bank #(.W_FRAME(WF), .W_MID(WM), .W_ERR(WE)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt_i    (evt),
        .rd_en_i  (rd_en),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data),
        .ovf_req_o(ovf_req)
    );

    // Layout from R9 / R10, written independently.
    function automatic int b_word(input int k);
        if (k < 2) return 0;
        if (k < 4) return 1;
        if (k < 7) return 2;
        if (k < 9) return 3;
        return 4;
    endfunction

    function automatic int b_lsb(input int k);
        int lsbs [12] = '{0, 24, 0, 24, 0, 8, 16, 0, 16, 0, 8, 16};
        return lsbs[k];
    endfunction

    function automatic int b_width(input int k);
        if (k == 0 || k == 2) return WF;
        if (k >= 6 && k <= 8) return WM;
        return WE;
    endfunction

    function automatic bit b_hit(input logic [7:0] a);
        return (a[1:0] == 2'b00) && (a >= 8'h30) && (a <= 8'h40);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    // One clock: drive, update model at the edge, compare after it.
    task automatic step(input logic [11:0] ev, input logic rd, input logic [7:0] addr, input string tag);
        int w;
        evt = ev; rd_en = rd; rd_addr = addr;
        @(posedge clk);
        w = (addr - 8'h30) / 4;
        exp_data = '0;
        if (rd && b_hit(addr))
            for (int k = 0; k < 12; k++)
                if (b_word(k) == w) exp_data |= 32'(ref_cnt[k]) << b_lsb(k);
        for (int k = 0; k < 12; k++) begin
            if (rd && b_hit(addr) && b_word(k) == w)
                ref_cnt[k] = ev[k] ? 1 : 0;
            else if (ev[k] && ref_cnt[k] < (1 << b_width(k)) - 1)
                ref_cnt[k]++;
        end
        exp_ovf = 1'b0;
        for (int k = 0; k < 12; k++)
            if (ref_cnt[k] >= (1 << (b_width(k) - 1))) exp_ovf = 1'b1;
        @(negedge clk);
        check(rd_data === exp_data, tag, rd_data, exp_data);
        check(ovf_req === exp_ovf, "R7 overflow request", 32'(ovf_req), 32'(exp_ovf));
    endtask

    task automatic read_all(input string tag);
        for (int w = 0; w < 5; w++) step('0, 1'b1, 8'(8'h30 + 4 * w), tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        for (int k = 0; k < 12; k++) ref_cnt[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(rd_data === 32'h0, "R1 data after reset", rd_data, 32'h0);
        check(ovf_req === 1'b0, "R1 overflow after reset", 32'(ovf_req), 32'h0);
        step('0, 1'b0, 8'h00, "R4 idle");
        read_all("R1 counters zero");

        // R2: single events per counter, a few each
        for (int k = 0; k < 12; k++)
            for (int n = 0; n <= k % 3; n++) step(12'(1 << k), 1'b0, 8'h00, "R4 idle");
        read_all("R2 single increments");
        read_all("R5 cleared after read");

        // R10: all counters in the same cycle
        repeat (2) step(12'hFFF, 1'b0, 8'h00, "R4 idle");
        read_all("R10 simultaneous events");

        // R3 / R7: drive everything past saturation
        repeat (40) step(12'hFFF, 1'b0, 8'h00, "R4 idle");
        step('0, 1'b1, 8'h38, "R3 saturated word 0x38");
        step('0, 1'b1, 8'h30, "R3 saturated word 0x30");
        step('0, 1'b1, 8'h34, "R3 saturated word 0x34");
        step('0, 1'b1, 8'h3C, "R3 saturated word 0x3C");
        step('0, 1'b1, 8'h40, "R9 unused bits of 0x40");

        // R6: event coincides with its clearing read
        repeat (3) step(12'h001, 1'b0, 8'h00, "R4 idle");
        step(12'h001, 1'b1, 8'h30, "R6 read excludes coincident event");
        step('0, 1'b1, 8'h30, "R6 counter restarted at one");

        // R8: invalid addresses clear nothing
        repeat (2) step(12'hFFF, 1'b0, 8'h00, "R4 idle");
        step('0, 1'b1, 8'h2C, "R8 below window");
        step('0, 1'b1, 8'h44, "R8 above window");
        step('0, 1'b1, 8'h31, "R8 misaligned");
        step('0, 1'b1, 8'h3E, "R8 misaligned");
        step('0, 1'b1, 8'hFF, "R8 far address");
        read_all("R8 counts kept after invalid reads");

        // R5 / R7 / R10: pseudo-random mix
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = lf[3] ? 8'(8'h30 + 4 * (lf[7:4] % 5)) : {lf[11:8], lf[15:12]};
            step(lf[11:0] & {12{lf[14]}}, lf[2] & lf[1], a, "R5 random mix");
        end
        read_all("R5 final drain");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule